// File: doc/BRIEF.md
# Dual-Channel PCM Codec Serial Port

This block is a four-wire serial port between a host and an external PCM voice codec: a bit clock, a frame sync, a data input and a data output with an enable. It carries two voice channels in each frame. Each channel sets its own start bit, its transmit and receive word lengths, and its transmit and receive bit orders. The host passes parallel samples in through a per-channel valid/ready port. Received words come back right-aligned with a one-cycle valid pulse.

In master mode the port divides the system clock to make the bit clock and frame sync. It can also hold the bit clock low for the tail of each frame as an idle gap. In slave mode it brings the codec's clock and frame sync into the system clock domain through synchronizers and follows them. The system clock must run at least four times faster than the bit clock. The configuration is a set of static inputs, and a combinational error flag reports settings that are not allowed.

Top module: `pcm_codec_port`

## Requirements
- R1: When `cfg_master`=1, `pcm_clk_o` is a square wave with half period `cfg_div`+1 system clocks, and `pcm_clk_oe` and `pcm_fs_oe` are 1. When `cfg_master`=0, both enables are 0.
- R2: In master mode a frame is `cfg_frame_len` bit clocks long. `pcm_fs_o` is high for exactly bit 0 of each frame, which is one bit period.
- R3: Channel c drives its transmit word on bits `cfg_pos[c]` to `cfg_pos[c]`+`cfg_len_out[c]`-1, where bit 0 is the frame-sync bit. `pcm_dout` changes at the rising edge of the bit clock.
- R4: Channel c samples `pcm_din` on the falling edge during bits `cfg_pos[c]` to `cfg_pos[c]`+`cfg_len_in[c]`-1. It then presents the word right-aligned on `rx_data[c]`, with `rx_valid[c]` high for one system clock after the last bit.
- R5: Bit order is set per channel and per direction. `cfg_msb_out[c]`/`cfg_msb_in[c]` = 1 means MSB first, and 0 means LSB first.
- R6: The receive and transmit lengths of a channel may differ. Transmit bits beyond `cfg_len_out` are not driven, so a looped-back line reads 0 there.
- R7: `pcm_dout_oe` is high only while a channel's transmit slot is in progress. It is 0 out of reset and 0 at all times while `cfg_hiz`=1. With the default slots of 16+16 bits, it is high for 32 bit periods per frame.
- R8: `tx_ready[c]` is 1 while the channel's one-word holding register is empty. An accepted word drops `tx_ready[c]` until the slot start takes the word.
- R9: If no word is held at the start of a transmit slot, zeros are sent and `tx_urun[c]` pulses for one system clock.
- R10: In master mode with `cfg_idle_start` N ≠ 0, `pcm_clk_o` stays low from bit N to the end of the frame, so a frame has N rising edges. The frame length in time is unchanged.
- R11: `cfg_err` is 1 when any of these holds: a length is outside 8..32; an LSB-first length exceeds 24; the two channel slots overlap; or, in master mode, a slot runs past the frame end or the idle start falls before a slot end.
- R12: When `cfg_master`=0, the port takes its timing from `pcm_clk_i` and `pcm_fs_i`. It transfers channel words from the first frame sync it sees.
- R13: Out of reset, `tx_ready` is 2'b11, `rx_valid` and `tx_urun` are 0, and `pcm_dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = generate clock and frame sync |
| cfg_div | input | DIVW | Half-period of bit clock minus one, in system clocks |
| cfg_frame_len | input | CW | Frame length in bit clocks (master) |
| cfg_idle_start | input | CW | Bit at which the clock idles, 0 = no idle |
| cfg_hiz | input | 1 | Force data output to high impedance |
| cfg_pos | input | 2xCW | Slot start bit per channel |
| cfg_len_in | input | 2xLW | Receive word length per channel |
| cfg_len_out | input | 2xLW | Transmit word length per channel |
| cfg_msb_in | input | 2 | Receive MSB first per channel |
| cfg_msb_out | input | 2 | Transmit MSB first per channel |
| cfg_err | output | 1 | Configuration not allowed |
| pcm_clk_i | input | 1 | Bit clock from codec (slave) |
| pcm_clk_o | output | 1 | Generated bit clock (master) |
| pcm_clk_oe | output | 1 | Bit clock output enable |
| pcm_fs_i | input | 1 | Frame sync from codec (slave) |
| pcm_fs_o | output | 1 | Generated frame sync (master) |
| pcm_fs_oe | output | 1 | Frame sync output enable |
| pcm_din | input | 1 | Serial data from codec |
| pcm_dout | output | 1 | Serial data to codec |
| pcm_dout_oe | output | 1 | Data output enable, 0 = high impedance |
| tx_data | input | 2xDW | Transmit word per channel |
| tx_valid | input | 2 | Transmit word offered |
| tx_ready | output | 2 | Holding register empty |
| tx_urun | output | 2 | Slot started with no word |
| rx_data | output | 2xDW | Received word, right-aligned |
| rx_valid | output | 2 | One-cycle received-word strobe |

## Verification
The bench loops the data output back to the data input. It sweeps channel 0 through mixed lengths and mixed bit orders, where a reversed index or a wrong shift direction would scramble the received word. Unequal in/out lengths test that bits past the transmit word read as zero and not as stale data. Frame measurements count rising clock edges, frame-sync width and output-enable time; a design that stopped the idle clock too early, widened the sync pulse or left the output driven between slots would show a wrong count. Missing-word underrun, forced high impedance, each error condition and a slave run on an external clock make up the rest.

// File: rtl/pcm_codec_port.sv
module pcm_codec_port #(
  parameter int DW      = 32,
  parameter int CW      = 10,
  parameter int LW      = 6,
  parameter int DIVW    = 12,
  parameter int MIN_LEN = 8,
  parameter int LSB_MAX = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_master,
  input  logic [DIVW-1:0]      cfg_div,
  input  logic [CW-1:0]        cfg_frame_len,
  input  logic [CW-1:0]        cfg_idle_start,
  input  logic                 cfg_hiz,
  input  logic [1:0][CW-1:0]   cfg_pos,
  input  logic [1:0][LW-1:0]   cfg_len_in,
  input  logic [1:0][LW-1:0]   cfg_len_out,
  input  logic [1:0]           cfg_msb_in,
  input  logic [1:0]           cfg_msb_out,
  output logic                 cfg_err,
  input  logic                 pcm_clk_i,
  output logic                 pcm_clk_o,
  output logic                 pcm_clk_oe,
  input  logic                 pcm_fs_i,
  output logic                 pcm_fs_o,
  output logic                 pcm_fs_oe,
  input  logic                 pcm_din,
  output logic                 pcm_dout,
  output logic                 pcm_dout_oe,
  input  logic [1:0][DW-1:0]   tx_data,
  input  logic [1:0]           tx_valid,
  output logic [1:0]           tx_ready,
  output logic [1:0]           tx_urun,
  output logic [1:0][DW-1:0]   rx_data,
  output logic [1:0]           rx_valid
);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] CMAX = '1;

  logic [DIVW-1:0] dc;
  logic clk_int, clk_q, fs_q, oe_q, dout_q;
  logic [2:0] cs;
  logic [1:0] fsy;
  logic [CW-1:0] cur, nb;
  logic [1:0] full;
  logic [1:0][DW-1:0] hold, sh, acc, wsrc, rx_nv;
  logic [1:0][CW-1:0] ko, ki;
  logic [1:0] in_o, in_i, bit_o;
  logic tick, rise_ev, fall_ev, idle_nb;

  assign tick    = dc >= cfg_div;
  assign rise_ev = cfg_master ? (tick & ~clk_int) : (cs[1] & ~cs[2]);
  assign fall_ev = cfg_master ? (tick & clk_int)  : (~cs[1] & cs[2]);
  assign idle_nb = (cfg_idle_start != '0) && (nb >= cfg_idle_start);

  assign pcm_clk_o   = clk_q;
  assign pcm_fs_o    = fs_q;
  assign pcm_clk_oe  = cfg_master;
  assign pcm_fs_oe   = cfg_master;
  assign pcm_dout    = dout_q;
  assign pcm_dout_oe = oe_q & ~cfg_hiz;
  assign tx_ready    = ~full;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      logic [IW-1:0] io;
      logic [DW-1:0] base;
      ko[c]   = nb - cfg_pos[c];
      ki[c]   = cur - cfg_pos[c];
      in_o[c] = (nb >= cfg_pos[c]) && (ko[c] < CW'(cfg_len_out[c]));
      in_i[c] = (cur >= cfg_pos[c]) && (ki[c] < CW'(cfg_len_in[c]));
      wsrc[c] = (ko[c] == '0) ? (full[c] ? hold[c] : '0) : sh[c];
      io      = cfg_msb_out[c] ? (IW'(cfg_len_out[c]) - IW'(1) - ko[c][IW-1:0]) : ko[c][IW-1:0];
      bit_o[c] = wsrc[c][io];
      base    = (ki[c] == '0) ? '0 : acc[c];
      rx_nv[c] = cfg_msb_in[c] ? {base[DW-2:0], pcm_din}
                               : (base | (DW'(pcm_din) << ki[c][IW-1:0]));
    end
  end

  always_comb begin
    logic [1:0][CW:0] endp;
    cfg_err = 1'b0;
    for (int c = 0; c < 2; c++) begin
      logic [LW-1:0] lmax;
      lmax    = (cfg_len_in[c] > cfg_len_out[c]) ? cfg_len_in[c] : cfg_len_out[c];
      endp[c] = (CW+1)'(cfg_pos[c]) + (CW+1)'(lmax);
      if (cfg_len_in[c] < LW'(MIN_LEN) || cfg_len_in[c] > LW'(DW) ||
          cfg_len_out[c] < LW'(MIN_LEN) || cfg_len_out[c] > LW'(DW)) cfg_err = 1'b1;
      if ((!cfg_msb_in[c] && cfg_len_in[c] > LW'(LSB_MAX)) ||
          (!cfg_msb_out[c] && cfg_len_out[c] > LW'(LSB_MAX))) cfg_err = 1'b1;
      if (cfg_master && endp[c] > {1'b0, cfg_frame_len}) cfg_err = 1'b1;
      if (cfg_master && cfg_idle_start != '0 && {1'b0, cfg_idle_start} < endp[c]) cfg_err = 1'b1;
    end
    if ({1'b0, cfg_pos[0]} < endp[1] && {1'b0, cfg_pos[1]} < endp[0]) cfg_err = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs <= '0; fsy <= '0; dc <= '0; clk_int <= 1'b0;
    end else begin
      cs  <= {cs[1:0], pcm_clk_i};
      fsy <= {fsy[0], pcm_fs_i};
      if (!cfg_master) begin
        dc <= '0; clk_int <= 1'b0;
      end else if (tick) begin
        dc <= '0; clk_int <= ~clk_int;
      end else dc <= dc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= CMAX; nb <= cfg_master ? '0 : CMAX;
      fs_q <= 1'b0; clk_q <= 1'b0; oe_q <= 1'b0; dout_q <= 1'b0;
    end else if (rise_ev) begin
      cur    <= nb;
      fs_q   <= cfg_master && (nb == '0);
      clk_q  <= cfg_master && !idle_nb;
      oe_q   <= |in_o;
      dout_q <= in_o[0] ? bit_o[0] : (in_o[1] ? bit_o[1] : 1'b0);
    end else if (fall_ev) begin
      clk_q <= 1'b0;
      if (cfg_master)      nb <= (cur >= cfg_frame_len - 1'b1) ? '0 : cur + 1'b1;
      else if (fsy[1])     nb <= CW'(1);
      else                 nb <= (cur == CMAX) ? CMAX : cur + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= '0; hold <= '0; sh <= '0; acc <= '0;
      rx_data <= '0; rx_valid <= '0; tx_urun <= '0;
    end else begin
      tx_urun  <= '0;
      rx_valid <= '0;
      for (int c = 0; c < 2; c++) begin
        if (rise_ev && in_o[c] && ko[c] == '0) begin
          sh[c]      <= wsrc[c];
          full[c]    <= 1'b0;
          tx_urun[c] <= !full[c];
        end
        if (tx_valid[c] && !full[c]) begin
          hold[c] <= tx_data[c];
          full[c] <= 1'b1;
        end
        if (fall_ev && in_i[c]) begin
          acc[c] <= rx_nv[c];
          if (ki[c] == CW'(cfg_len_in[c]) - 1'b1) begin
            rx_data[c]  <= rx_nv[c];
            rx_valid[c] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_codec_port_chk.sv
module pcm_codec_port_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_master,
  input logic          cfg_err,
  input logic [CW-1:0] cfg_idle_start,
  input logic [CW-1:0] cur,
  input logic          pcm_clk_o,
  input logic          pcm_fs_o,
  input logic          pcm_dout,
  input logic          pcm_dout_oe,
  input logic [1:0]    tx_valid,
  input logic [1:0]    tx_ready,
  input logic [1:0]    rx_valid
);
  // R2
  fs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_fs_o) |-> cur == '0);

  // R10
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && $rose(pcm_clk_o) |-> (cfg_idle_start == '0 || cur < cfg_idle_start));

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || cfg_err || !cfg_master)
    !$rose(pcm_clk_o) |-> $stable(pcm_dout));

  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid[0] || rx_valid[1] |=> !rx_valid[0] && !rx_valid[1]);

  // R8
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid[0] && tx_ready[0] |=> !tx_ready[0]);

  // R7
  oe_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !pcm_dout_oe);
endmodule

bind pcm_codec_port pcm_codec_port_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_err(cfg_err),
  .cfg_idle_start(cfg_idle_start), .cur(cur), .pcm_clk_o(pcm_clk_o),
  .pcm_fs_o(pcm_fs_o), .pcm_dout(pcm_dout), .pcm_dout_oe(pcm_dout_oe),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid)
);

// File: tb/tb_pcm_codec_port.sv
module tb_pcm_codec_port;
  logic clk = 0, rst_n = 0;
  logic cfg_master = 1, cfg_hiz = 0, cfg_err;
  logic [11:0] cfg_div = 12'd3;
  logic [9:0] cfg_frame_len = 10'd64, cfg_idle_start = 10'd0;
  logic [1:0][9:0] cfg_pos;
  logic [1:0][5:0] cfg_len_in, cfg_len_out;
  logic [1:0] cfg_msb_in = 2'b11, cfg_msb_out = 2'b11;
  logic pcm_clk_o, pcm_clk_oe, pcm_fs_o, pcm_fs_oe, pcm_din, pcm_dout, pcm_dout_oe;
  logic pclk = 0, pfs = 0, slave_run = 0;
  int bc = 63;
  logic [1:0][31:0] tx_data = '0, rx_data;
  logic [1:0] tx_valid = '0, tx_ready, tx_urun, rx_valid;
  int total = 0, bad = 0, wd = 0;

  localparam int NV = 6;
  localparam int V_LO [NV] = '{16, 16, 24, 8, 20, 32};
  localparam int V_LI [NV] = '{16, 16, 24, 12, 8, 32};
  localparam bit V_MO [NV] = '{1, 1, 0, 1, 0, 1};
  localparam bit V_MI [NV] = '{1, 0, 0, 1, 1, 1};
  localparam int V_P  [NV] = '{2, 3, 2, 5, 4, 2};
  localparam logic [31:0] V_D [NV] = '{32'hA5C31234, 32'h00001234, 32'h00ABCDEF,
                                       32'h000000FF, 32'h00012345, 32'hDEADBEEF};

  assign pcm_din = pcm_dout_oe ? pcm_dout : 1'b0;

  pcm_codec_port dut (.*, .pcm_clk_i(pclk), .pcm_fs_i(pfs));

  always #5 clk = ~clk;
  always #40 if (slave_run) pclk = ~pclk;
  always @(posedge pclk) begin
    bc = (bc == 63) ? 0 : bc + 1;
    pfs = (bc == 0);
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rx(input logic [31:0] d, input int lo, input int li,
                                         input bit mo, input bit mi);
    logic [31:0] r = '0;
    for (int k = 0; k < li; k++) begin
      logic s;
      s = (k < lo) ? (mo ? d[lo-1-k] : d[k]) : 1'b0;
      if (mi) r = {r[30:0], s}; else r[k] = s;
    end
    return r;
  endfunction

  task automatic wait_fs();
    logic prev = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pcm_fs_o && !prev) return;
      prev = pcm_fs_o;
    end
  endtask

  task automatic frame_stats(output int cyc, output int rises, output int hi, output int oe, output int fsc);
    logic pc = 1'b0, pf = 1'b0;
    cyc = 0; rises = 0; hi = 0; oe = 0; fsc = 0;
    for (int i = 0; i < 5000; i++) begin
      if (i > 0 && pcm_fs_o && !pf) return;
      cyc++;
      if (pcm_clk_o && !pc) rises++;
      if (pcm_clk_o) hi++;
      if (pcm_dout_oe) oe++;
      if (pcm_fs_o) fsc++;
      pc = pcm_clk_o; pf = pcm_fs_o;
      @(negedge clk);
    end
  endtask

  task automatic push(input int c, input logic [31:0] d);
    @(negedge clk);
    tx_data[c] = d; tx_valid[c] = 1'b1;
    @(negedge clk);
    tx_valid[c] = 1'b0;
  endtask

  task automatic wait_rx(input int c, output logic [31:0] d, output bit urun);
    d = 'x; urun = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tx_urun[c]) urun = 1;
      if (rx_valid[c]) begin d = rx_data[c]; return; end
    end
  endtask

  task automatic set_ch0(input int v);
    cfg_pos[0] = 10'(V_P[v]); cfg_len_out[0] = 6'(V_LO[v]); cfg_len_in[0] = 6'(V_LI[v]);
    cfg_msb_out[0] = V_MO[v]; cfg_msb_in[0] = V_MI[v];
  endtask

  initial begin
    int cyc, rises, hi, oe, fsc;
    logic [31:0] d;
    bit ur;
    cfg_pos[1] = 10'd40; cfg_len_in[1] = 6'd16; cfg_len_out[1] = 6'd16;
    set_ch0(0);
    repeat (4) @(negedge clk);
    // R13, R7: reset state
    chk("R13 tx_ready", 32'(tx_ready), 32'h3);
    chk("R13 rx_valid", 32'(rx_valid), 32'h0);
    chk("R7 oe in reset", 32'(pcm_dout_oe), 32'h0);
    chk("R1 master enables", 32'({pcm_clk_oe, pcm_fs_oe}), 32'h3);
    rst_n = 1;

    wait_fs();
    frame_stats(cyc, rises, hi, oe, fsc);
    // R1, R2, R7
    chk("R2 frame cycles", 32'(cyc), 32'd512);
    chk("R2 fs width", 32'(fsc), 32'd8);
    chk("R1 clock rises", 32'(rises), 32'd64);
    chk("R1 clock high time", 32'(hi), 32'd256);
    chk("R7 oe time", 32'(oe), 32'd256);

    // R3 R4 R5 R6: table of slot/order/length vectors
    for (int v = 0; v < NV; v++) begin
      wait_fs();
      set_ch0(v);
      push(0, V_D[v]);
      chk("R8 ready drops", 32'(tx_ready[0]), 32'h0);
      wait_rx(0, d, ur);
      chk($sformatf("R5 R6 vector %0d", v), d, exp_rx(V_D[v], V_LO[v], V_LI[v], V_MO[v], V_MI[v]));
    end
    set_ch0(0);

    // R3 R4: both channels in one frame
    wait_fs();
    push(0, 32'h1111);
    push(1, 32'h0000BEEF);
    wait_rx(1, d, ur);
    chk("R4 channel 1 word", d, 32'hBEEF);
    chk("R8 ready back", 32'(tx_ready), 32'h3);

    // R9: underrun
    wait_fs();
    wait_rx(0, d, ur);
    chk("R9 zeros sent", d, 32'h0);
    chk("R9 underrun pulse", 32'(ur), 32'h1);

    // R7: forced high impedance
    wait_fs();
    cfg_hiz = 1;
    push(0, 32'hFFFF);
    frame_stats(cyc, rises, hi, oe, fsc);
    chk("R7 hiz oe", 32'(oe), 32'd0);
    push(0, 32'hFFFF);
    wait_rx(0, d, ur);
    chk("R7 hiz line", d, 32'h0);
    cfg_hiz = 0;

    // R10: idle period
    wait_fs();
    cfg_idle_start = 10'd60;
    wait_fs();
    frame_stats(cyc, rises, hi, oe, fsc);
    chk("R10 idle rises", 32'(rises), 32'd60);
    chk("R10 frame time", 32'(cyc), 32'd512);

    // R11: configuration errors
    @(negedge clk);
    chk("R11 clean", 32'(cfg_err), 32'h0);
    cfg_idle_start = 10'd50; #1;
    chk("R11 idle before slot end", 32'(cfg_err), 32'h1);
    cfg_idle_start = 10'd0; cfg_pos[0] = 10'd35; #1;
    chk("R11 overlap", 32'(cfg_err), 32'h1);
    cfg_pos[0] = 10'd2; cfg_msb_out[0] = 0; cfg_len_out[0] = 6'd28; #1;
    chk("R11 lsb too long", 32'(cfg_err), 32'h1);
    cfg_msb_out[0] = 1; cfg_len_out[0] = 6'd6; #1;
    chk("R11 too short", 32'(cfg_err), 32'h1);
    cfg_pos[1] = 10'd60; cfg_len_out[0] = 6'd16; #1;
    chk("R11 past frame end", 32'(cfg_err), 32'h1);
    cfg_pos[1] = 10'd40; set_ch0(0);

    // R12: slave mode
    @(negedge clk);
    rst_n = 0; cfg_master = 0;
    repeat (3) @(negedge clk);
    chk("R1 slave enables", 32'({pcm_clk_oe, pcm_fs_oe}), 32'h0);
    rst_n = 1; slave_run = 1;
    @(posedge pfs); @(negedge clk);
    push(0, 32'h00005A5A);
    wait_rx(0, d, ur);
    chk("R12 slave word", d, 32'h5A5A);
    @(posedge pfs); @(negedge clk);
    cfg_msb_out[0] = 0;
    push(0, 32'h000000C3);
    wait_rx(0, d, ur);
    chk("R12 R5 slave lsb out", d, exp_rx(32'hC3, 16, 16, 0, 1));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule